// File: doc/BRIEF.md
# Change Sequence Detector

This block watches a one-bit serial input, taking one sample on every rising clock edge. It raises a detect flag when the two most recent samples differ, that is when the stream has just produced the pair 0-then-1 or the pair 1-then-0. In other words, the flag marks every transition on the input. The main output comes from a five-state Moore machine whose flag depends only on the current state. Because of this the flag is glitch-free and lags by exactly one cycle the sample that completes a pair.

A dedicated idle state is entered on reset. It has no notion of a previous sample, so the first sample taken after reset can never produce a detection. A second output, enabled by a parameter, comes from a three-state Mealy machine. Its flag is formed from its state and the live input, so it announces the same event one cycle earlier. It is provided so that the two forms can be compared side by side. Neither output synchronises the input: `din` must already be in the clock domain.

Top module: `chg_seq_detect`

## Requirements
- R1: While `rst_n` is low at a rising edge, the Moore machine returns to its idle state, and `moore_det` reads 0 in the following cycle whatever `din` does.
- R2: The first sample taken after reset never causes a detection: `moore_det` is 0 in the cycle after that sample, even if it differs from the last sample taken before reset.
- R3: A sample of 1 that follows a sample of 0 sets `moore_det` to 1 for the cycle after the edge that took the 1.
- R4: A sample of 0 that follows a sample of 1 sets `moore_det` to 1 for the cycle after the edge that took the 0.
- R5: A sample equal to the previous one (a run of 0s or a run of 1s) leaves `moore_det` at 0 for the following cycle.
- R6: A strictly alternating stream keeps `moore_det` at 1 on every cycle from the second sample of the alternation onward, with no gap.
- R7: `mealy_det` equals the live `din` XOR the last sample taken, with no clock delay. It is 0 whenever no sample has been taken since reset.
- R8: Whenever reset stays released, the value of `mealy_det` just before an edge equals the value of `moore_det` just after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one sample per edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data input, already synchronous to `clk` |
| moore_det | output | 1 | Registered-state detect flag, one cycle after the completing sample |
| mealy_det | output | 1 | Same-cycle detect flag from state and live input; 0 when disabled |

## Verification
The bench applies reset in the middle of a stream whose last bit differs from the first bit after reset. A design that carried history across reset would flag a false transition there. Runs of equal bits in both polarities catch a machine that confuses a held level with a change. A long alternating burst catches a machine that drops a cycle when moving directly between its two detecting states. Toggling `din` while reset is held catches a reset that is not given priority over the input. The Mealy flag is sampled half a cycle after each new bit and compared with the Moore flag of the next cycle. This exposes an output built from the wrong state or delayed by a register.

// File: rtl/chg_det_pkg.sv
// Package: shared state encodings for the change sequence detector.
// Assumes: both machines are small enough that binary encoding is adequate.
package chg_det_pkg;

    localparam int unsigned MOORE_STATES = 5;
    localparam int unsigned MOORE_W      = $clog2(MOORE_STATES);
    localparam int unsigned MEALY_STATES = 3;
    localparam int unsigned MEALY_W      = $clog2(MEALY_STATES);

    // Moore states: IDLE has no history, LOW/HIGH hold a level,
    // RISE/FALL mean the last two samples were 01 / 10.
    typedef enum logic [MOORE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_LOW  = 3'd1,
        ST_HIGH = 3'd2,
        ST_RISE = 3'd3,
        ST_FALL = 3'd4
    } moore_st_t;

    // Mealy states only remember the last sample, if any.
    typedef enum logic [MEALY_W-1:0] {
        MS_IDLE = 2'd0,
        MS_LOW  = 2'd1,
        MS_HIGH = 2'd2
    } mealy_st_t;

endpackage

// File: rtl/chg_moore_core.sv
// Module: chg_moore_core
// Five-state Moore machine that flags a change between consecutive samples.
// The flag is decoded from the state alone, so it moves only after a clock edge.
// Assumes: din is synchronous to clk; rst_n is synchronous, active low.
module chg_moore_core
    import chg_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic det
);

    moore_st_t state_q;
    moore_st_t state_d;

    // Next-state function of the current state and the sample.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = din ? ST_HIGH : ST_LOW;
            ST_LOW:  state_d = din ? ST_RISE : ST_LOW;
            ST_HIGH: state_d = din ? ST_HIGH : ST_FALL;
            ST_RISE: state_d = din ? ST_HIGH : ST_FALL;
            ST_FALL: state_d = din ? ST_RISE : ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to the idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode: only the two "pair seen" states detect.
    always_comb begin
        unique case (state_q)
            ST_RISE, ST_FALL: det = 1'b1;
            default:          det = 1'b0;
        endcase
    end

    // R1: state register never leaves the legal encodings.
    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_IDLE, ST_LOW, ST_HIGH, ST_RISE, ST_FALL});

    // R2: nothing is flagged for the first sample out of idle.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !det);

    // R3: a 1 after a held or falling 0 must be flagged.
    assert_low_to_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOW || state_q == ST_FALL) && din) |=> det);

    // R4: a 0 after a held or rising 1 must be flagged.
    assert_high_to_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HIGH || state_q == ST_RISE) && !din) |=> det);

endmodule

// File: rtl/chg_mealy_core.sv
// Module: chg_mealy_core
// Three-state Mealy machine: remembers the last sample and flags a change
// combinationally from that memory and the live input.
// Assumes: din is synchronous to clk; rst_n is synchronous, active low.
module chg_mealy_core
    import chg_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic det
);

    mealy_st_t state_q;

    // State register: record the level just sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= din ? MS_HIGH : MS_LOW;
    end

    // Arc output: a change relative to the stored level, never from idle.
    always_comb begin
        unique case (state_q)
            MS_LOW:  det = din;
            MS_HIGH: det = !din;
            default: det = 1'b0;
        endcase
    end

    // R7: the reset arc carries no detection.
    assert_mealy_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_IDLE) |-> !det);

endmodule

// File: rtl/chg_seq_detect.sv
// Module: chg_seq_detect (top)
// Serial detector flagging any 01 or 10 pair on din. The Moore flag is always
// present; the Mealy flag is built only when HAS_MEALY is set, else tied to 0.
// Assumes: din is synchronous to clk; rst_n is synchronous, active low.
module chg_seq_detect #(
    parameter bit HAS_MEALY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic moore_det,
    output logic mealy_det
);

    // Moore detector: registered-state flag.
    chg_moore_core u_moore (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .det   (moore_det)
    );

    // Optional Mealy detector, chosen by parameter.
    generate
        if (HAS_MEALY) begin : g_mealy
            chg_mealy_core u_mealy (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (din),
                .det   (mealy_det)
            );

            // R8: the Mealy flag before an edge predicts the Moore flag after it.
            assert_mealy_leads_R8: assert property (@(posedge clk) disable iff (!rst_n)
                mealy_det |=> moore_det);
            assert_mealy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !mealy_det |=> !moore_det);
        end else begin : g_no_mealy
            assign mealy_det = 1'b0;
        end
    endgenerate

endmodule

// File: tb/chg_seq_detect_tb_top.sv
// Scoreboard bench: the driver pushes expected Moore flags into a queue, the
// monitor pops one per clock and compares; Mealy is checked by the driver.
module chg_seq_detect_tb_top;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic moore_det;
    logic mealy_det;

    int checks = 0;
    int errors = 0;
    item_t sb_q[$];
    logic prev_bit = 1'b0;
    logic prev_valid = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chg_seq_detect dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .moore_det (moore_det),
        .mealy_det (mealy_det)
    );

    // Compare one observed value with its expectation.
    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Hold reset for n cycles while din toggles; Moore flag expected low.
    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = 1'b0;
            din = i[0];
            sb_q.push_back('{exp: 1'b0, tag: "R1"});
            #1;
            if (i > 0) check("R1", "mealy_det in reset", mealy_det, 1'b0);
        end
        prev_valid = 1'b0;
    endtask

    // Drive one sample; expectation follows the requirements directly.
    task automatic send_bit(input logic b, input string alt_tag);
        logic  e;
        string t;
        @(negedge clk);
        rst_n = 1'b1;
        din = b;
        e = prev_valid && (b != prev_bit);
        if (!prev_valid)       t = "R2";
        else if (alt_tag != "") t = alt_tag;
        else if (e && b)       t = "R3";
        else if (e)            t = "R4";
        else                   t = "R5";
        sb_q.push_back('{exp: e, tag: t});
        #1;
        check("R7", "mealy_det", mealy_det, e);
        prev_bit = b;
        prev_valid = 1'b1;
    endtask

    // Monitor: one expectation per edge, sampled just after the edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, "moore_det", moore_det, it.exp);
        end
    end

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(3);
        // R2 first sample, then R5 runs, R3 and R4 single changes.
        send_bit(1'b0, "");
        send_bit(1'b0, "");
        send_bit(1'b0, "");
        send_bit(1'b1, "");
        send_bit(1'b1, "");
        send_bit(1'b1, "");
        send_bit(1'b0, "");
        send_bit(1'b0, "");
        // R6 alternating burst: every sample flags.
        for (int i = 0; i < 8; i++) send_bit(i[0] ? 1'b0 : 1'b1, "R6");
        send_bit(1'b0, "");
        send_bit(1'b1, "");
        // R2: reset between a 1 and a 0 must not flag.
        do_reset(2);
        send_bit(1'b0, "");
        send_bit(1'b1, "");
        send_bit(1'b1, "");
        // R2: reset between a 0 and a 1 must not flag.
        send_bit(1'b0, "");
        do_reset(1);
        send_bit(1'b1, "");
        send_bit(1'b0, "");
        send_bit(1'b1, "R6");
        // Drain the scoreboard.
        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending items", sb_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule